// File: doc/BRIEF.md
# Iterative Multiply Unit with Upper/Lower Result Registers

This block is the multiply unit on the processor side of a core. A single start pulse launches a multiply of two 32-bit operands, either as two's complement values or as unsigned values. The unit works out the product over several cycles. When it finishes, it writes the 64-bit result into two dedicated registers that sit apart from the general register file. The upper-word register takes bits 63..32 and the lower-word register takes bits 31..0. Both registers change on the same clock edge and hold their previous contents until that edge.

Two independent read ports stand in for the move-from-upper and move-from-lower operations. A read request is answered with ready only while the unit is idle. During a multiply the request stalls with ready held low.

A multiply never raises an exception. Instead the unit exports a flag that tells software whether the product fits in one 32-bit word. For an unsigned product the flag is set when the upper word is zero. For a signed product it is set when every bit of the upper word equals bit 31 of the lower word.

Top module: `mul_hilo_unit`

## Requirements
- R1: While reset is asserted and after it is released, with no operation started, the upper and lower registers read zero, the fits flag reads 1 and busy reads 0.
- R2: A start pulse seen while idle raises busy on the next cycle. Busy then stays high for exactly WIDTH+2 consecutive cycles (34 with the default width).
- R3: With the signed select at 0, the concatenation {upper, lower} equals the unsigned 64-bit product of the two operands once busy falls.
- R4: With the signed select at 1, {upper, lower} equals the two's complement 64-bit product of the two operands read as signed 32-bit values.
- R5: While busy is high, the upper register, the lower register and the fits flag keep their previous values. All three change together on the edge that ends the operation.
- R6: Each read port returns ready only when its request is high and busy is low. A request during busy sees ready low. The data outputs always show the register contents.
- R7: After an unsigned operation, the fits flag is 1 exactly when the upper word is all zeros.
- R8: After a signed operation, the fits flag is 1 exactly when every upper-word bit equals bit 31 of the lower word.
- R9: A start pulse that arrives while busy is ignored. The result, the signedness and the busy length come only from the operation already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Launch a multiply; sampled only while idle |
| signed_i | input | 1 | 1 selects a signed multiply, 0 an unsigned one |
| opa_i | input | 32 | Multiplicand |
| opb_i | input | 32 | Multiplier |
| busy_o | output | 1 | High while a multiply is in progress |
| hi_req_i | input | 1 | Move-from-upper request |
| hi_rdy_o | output | 1 | Upper read accepted |
| hi_o | output | 32 | Upper-word register contents |
| lo_req_i | input | 1 | Move-from-lower request |
| lo_rdy_o | output | 1 | Lower read accepted |
| lo_o | output | 32 | Lower-word register contents |
| fits_o | output | 1 | Result fits in 32 bits for the signedness of the last operation |

## Verification
Two situations are hard to reach from the ports. The first is a start pulse that lands in the middle of a running multiply. The bench injects a second start with different operands and the opposite signedness a few cycles into some operations. It then checks that the result and the busy length belong to the first operation alone. The second is the operand at the very bottom of the signed range (the most negative value), together with all-ones patterns. These sit at the edges of the fits rule and of the internal recoding, so directed cases cover them. A seeded random mix of signed and unsigned operations then exercises the rest.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_COMMIT = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_rst_sync.sv
module mul_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic commit_o,
  output logic busy_o
);
  localparam int STEPS = WIDTH + 1;
  localparam int CW    = $clog2(STEPS + 1);

  mul_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = CW'(STEPS);
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) state_d = ST_COMMIT;
      end
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign step_o   = (state_q == ST_RUN);
  assign commit_o = (state_q == ST_COMMIT);
  assign busy_o   = (state_q != ST_IDLE);

  // R2: the step counter never runs dry while iterating
  p_cnt_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (cnt_q != '0));
  // R2: completion is followed by idle
  p_commit_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (state_q == ST_IDLE));
  // R9: a start during a run does not end or restart it
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && start_i && cnt_q > CW'(1)) |=> (step_o && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mul_booth_dp.sv
module mul_booth_dp #(
  parameter int WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               commit_i,
  input  logic               sgn_i,
  input  logic [WIDTH-1:0]   opa_i,
  input  logic [WIDTH-1:0]   opb_i,
  output logic               sgn_o,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int EXT = WIDTH + 1;  // multiplier extended by one bit
  localparam int AW  = WIDTH + 2;  // accumulator with guard bit
  localparam int FW  = AW + EXT;

  logic [AW-1:0]  acc_q, acc_d, mcand_q, mcand_d, sum;
  logic [EXT-1:0] mq_q, mq_d;
  logic           qm1_q, qm1_d, sgn_q, sgn_d;
  logic [FW-1:0]  full;

  always_comb begin
    unique case ({mq_q[0], qm1_q})
      2'b10:   sum = acc_q - mcand_q;
      2'b01:   sum = acc_q + mcand_q;
      default: sum = acc_q;
    endcase
  end

  always_comb begin
    acc_d   = acc_q;
    mq_d    = mq_q;
    qm1_d   = qm1_q;
    mcand_d = mcand_q;
    sgn_d   = sgn_q;
    if (load_i) begin
      acc_d   = '0;
      mq_d    = {sgn_i & opb_i[WIDTH-1], opb_i};
      qm1_d   = 1'b0;
      mcand_d = {{2{sgn_i & opa_i[WIDTH-1]}}, opa_i};
      sgn_d   = sgn_i;
    end else if (step_i) begin
      acc_d   = {sum[AW-1], sum[AW-1:1]};
      mq_d    = {sum[0], mq_q[EXT-1:1]};
      qm1_d   = mq_q[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mq_q    <= '0;
      qm1_q   <= 1'b0;
      mcand_q <= '0;
      sgn_q   <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      mq_q    <= mq_d;
      qm1_q   <= qm1_d;
      mcand_q <= mcand_d;
      sgn_q   <= sgn_d;
    end
  end

  assign full   = {acc_q, mq_q};
  assign prod_o = full[2*WIDTH-1:0];
  assign sgn_o  = sgn_q;

  // R3: an unsigned product never spills past 2*WIDTH bits
  p_uns_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !sgn_q) |-> (full[FW-1:2*WIDTH] == '0));
  // R4: a signed product is a proper sign extension of its low 2*WIDTH bits
  p_sgn_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && sgn_q) |-> (full[FW-1:2*WIDTH-1] == '0 || full[FW-1:2*WIDTH-1] == '1));
endmodule

// File: rtl/mul_hilo_regs.sv
module mul_hilo_regs #(
  parameter int WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic               sgn_i,
  input  logic [2*WIDTH-1:0] prod_i,
  output logic [WIDTH-1:0]   hi_o,
  output logic [WIDTH-1:0]   lo_o,
  output logic               fits_o
);
  logic [WIDTH-1:0] hi_q, hi_d, lo_q, lo_d;
  logic             fits_q, fits_d, sgn_q, sgn_d;

  always_comb begin
    hi_d   = hi_q;
    lo_d   = lo_q;
    sgn_d  = sgn_q;
    fits_d = fits_q;
    if (commit_i) begin
      hi_d   = prod_i[2*WIDTH-1:WIDTH];
      lo_d   = prod_i[WIDTH-1:0];
      sgn_d  = sgn_i;
      fits_d = sgn_i ? (prod_i[2*WIDTH-1:WIDTH] == {WIDTH{prod_i[WIDTH-1]}})
                     : (prod_i[2*WIDTH-1:WIDTH] == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      sgn_q  <= 1'b0;
      fits_q <= 1'b1;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      sgn_q  <= sgn_d;
      fits_q <= fits_d;
    end
  end

  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign fits_o = fits_q;

  // R5: result state moves only on the completion edge
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(hi_q) && $stable(lo_q) && $stable(fits_q)));
  // R7: unsigned fit rule
  p_fits_uns_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sgn_q |-> (fits_q == (hi_q == '0)));
  // R8: signed fit rule
  p_fits_sgn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sgn_q |-> (fits_q == (hi_q == {WIDTH{lo_q[WIDTH-1]}})));
endmodule

// File: rtl/mul_hilo_unit.sv
module mul_hilo_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             busy_o,
  input  logic             hi_req_i,
  output logic             hi_rdy_o,
  output logic [WIDTH-1:0] hi_o,
  input  logic             lo_req_i,
  output logic             lo_rdy_o,
  output logic [WIDTH-1:0] lo_o,
  output logic             fits_o
);
  logic               rst_n;
  logic               load, step, commit, busy, sgn;
  logic [2*WIDTH-1:0] prod;

  mul_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n));

  mul_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_n), .start_i(start_i),
    .load_o(load), .step_o(step), .commit_o(commit), .busy_o(busy));

  mul_booth_dp #(.WIDTH(WIDTH)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_n), .load_i(load), .step_i(step),
    .commit_i(commit), .sgn_i(signed_i), .opa_i(opa_i), .opb_i(opb_i),
    .sgn_o(sgn), .prod_o(prod));

  mul_hilo_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .commit_i(commit), .sgn_i(sgn),
    .prod_i(prod), .hi_o(hi_o), .lo_o(lo_o), .fits_o(fits_o));

  assign busy_o   = busy;
  assign hi_rdy_o = hi_req_i & ~busy;
  assign lo_rdy_o = lo_req_i & ~busy;

  // R6: move-from reads stall while the multiply runs
  p_rd_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy_o |-> (!hi_rdy_o && !lo_rdy_o));
  // R2: an accepted start raises busy
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: tb/mul_hilo_unit_bench.sv
module mul_hilo_unit_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, sgn = 1'b0, hi_req = 1'b0, lo_req = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic         busy, hi_rdy, lo_rdy, fits;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mul_hilo_unit #(.WIDTH(W)) u_mul_hilo_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .opa_i(opa), .opb_i(opb), .busy_o(busy),
    .hi_req_i(hi_req), .hi_rdy_o(hi_rdy), .hi_o(hi),
    .lo_req_i(lo_req), .lo_rdy_o(lo_rdy), .lo_o(lo), .fits_o(fits));

  function automatic logic [2*W-1:0] exp_prod(logic s, logic [W-1:0] a, logic [W-1:0] b);
    logic signed [2*W-1:0] sa, sb;
    if (s) begin
      sa = {{W{a[W-1]}}, a};
      sb = {{W{b[W-1]}}, b};
      return sa * sb;
    end
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  function automatic logic exp_fits(logic s, logic [2*W-1:0] p);
    if (s) return p[2*W-1:W] == {W{p[W-1]}};
    return p[2*W-1:W] == '0;
  endfunction

  task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Runs one multiply; inject=1 pulses a conflicting start mid-run (R9)
  task automatic run_op(logic s, logic [W-1:0] a, logic [W-1:0] b, bit inject);
    logic [W-1:0]     old_hi, old_lo;
    logic             old_fits;
    logic [2*W-1:0]   p;
    int               cyc;
    bit               held, stalled;
    p = exp_prod(s, a, b);
    old_hi = hi; old_lo = lo; old_fits = fits;
    @(negedge clk);
    start = 1'b1; sgn = s; opa = a; opb = b;
    hi_req = 1'b1; lo_req = 1'b1;
    @(negedge clk);
    start = 1'b0; opa = ~a; opb = b ^ 32'h5a5a_a5a5; sgn = ~s;
    cyc = 0; held = 1'b1; stalled = 1'b1;
    while (busy) begin
      cyc++;
      if (hi !== old_hi || lo !== old_lo || fits !== old_fits) held = 1'b0;
      if (hi_rdy || lo_rdy) stalled = 1'b0;
      if (inject && cyc == 5) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check("R2 busy length", cyc, W + 2);
    check("R5 registers held while busy", held, 1'b1);
    check("R6 ready low while busy", stalled, 1'b1);
    check(s ? "R4 signed product" : "R3 unsigned product", {hi, lo}, p);
    check(s ? "R8 signed fits" : "R7 unsigned fits", fits, exp_fits(s, p));
    check("R6 ready when idle", {hi_rdy, lo_rdy}, 2'b11);
    if (inject) check("R9 start while busy ignored", {busy, hi, lo}, {1'b0, p});
    hi_req = 1'b0; lo_req = 1'b0;
    @(negedge clk);
    check("R6 no ready without request", {hi_rdy, lo_rdy}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset state", {busy, fits, hi, lo}, {1'b0, 1'b1, {2*W{1'b0}}});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {busy, fits, hi, lo}, {1'b0, 1'b1, {2*W{1'b0}}});

    run_op(1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0);
    run_op(1'b0, 32'hffff_ffff, 32'hffff_ffff, 1'b0);
    run_op(1'b0, 32'hffff_ffff, 32'h0000_0001, 1'b0);
    run_op(1'b1, 32'hffff_ffff, 32'h0000_0001, 1'b0);
    run_op(1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0);
    run_op(1'b1, 32'h8000_0000, 32'h0000_0001, 1'b0);
    run_op(1'b1, 32'hffff_ffff, 32'hffff_ffff, 1'b0);
    run_op(1'b1, 32'h7fff_ffff, 32'h8000_0000, 1'b1);
    run_op(1'b0, 32'h0001_0000, 32'h0000_ffff, 1'b1);
    run_op(1'b1, 32'hffff_fffb, 32'hffff_fffd, 1'b0);

    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      logic s;
      a = $urandom();
      b = $urandom();
      if (i % 4 == 0) a = a >> ($urandom() % 32);
      if (i % 5 == 0) b = {W{b[W-1]}} ^ (b >> 20);
      s = i[0];
      run_op(s, a, b, (i % 7) == 3);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule